// File: doc/BRIEF.md
# Video Channel Auto Offset Loop

This block closes a digital loop around the offset DAC of one video digitizer channel. Each time the clamp interval ends, the channel's sampled code is captured. On an update event the block compares that code with a target code and moves a signed offset word toward the value that brings the sample onto the target. The offset word drives the external DAC. When the loop is not selected, a manual offset passes straight through to the same output.

The correction path is fixed. The error is scaled by a power of two, or replaced by the whole error when the error is large. The step is then limited to a programmed slew, and the result saturates at the signed range of the offset word. Two optional filters sit in front of the offset register. A vote filter lets a change through only after six agreeing evaluations. A toggle filter freezes the loop when the offset bounces between two values.

The tuning fields sit in a register with reset defaults. A single write strobe loads every field at once. The enable, hold and manual offset inputs act directly.

Top module: `auto_offset_loop`

## Requirements
- R1: With `auto_en` low, `offset_out` equals `manual_offset` and clamp or vsync events have no effect. The loop register follows `manual_offset`, so auto mode starts from the manual value.
- R2: With `auto_en` high and `hold` high, `offset_out` does not change, whatever events arrive.
- R3: The cadence field selects the update events. 0 means every clamp, 1 means every 16th clamp, 2 means every 64th clamp, and 3 means every vsync pulse, which uses the code from the most recent clamp. The reset value is 2. A tuning write restarts the clamp count. An update caused by a clamp shows on `offset_out` two clock edges after the edge that samples `clamp_done`.
- R4: The error is target minus sampled code. A positive error raises the offset. The shift field scales the error magnitude: 0 gives the full error, 1 gives one half, 2 gives one quarter and 3 gives one eighth. Division truncates toward zero. The reset value is 1.
- R5: With the jump bit set and an error magnitude greater than 15, the step is the whole error and no shift is applied. An error of exactly 15 is shifted as usual. The jump bit is set at reset.
- R6: With the vote filter on, the offset changes only on the sixth consecutive evaluation that recommends a change in the same direction. A zero step or a reversal of direction restarts the count. The filter is on at reset.
- R7: With the toggle filter on, an applied change that reverses the previous applied change and returns the offset to its earlier value locks the loop. While locked, the offset stays put. The lock releases after the error direction changes sign twice, or on a tuning write. The filter is off at reset.
- R8: No single applied change exceeds the slew field in magnitude. This includes jumps. The reset value is 8.
- R9: The offset saturates at 255 and at -256 and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clamp_done | input | 1 | One-cycle strobe at the end of the clamp interval |
| vsync | input | 1 | One-cycle frame strobe |
| sample_code | input | 8 | Channel code sampled in the clamp interval, valid with `clamp_done` |
| target_code | input | 8 | Code the loop steers toward |
| auto_en | input | 1 | 1 selects the closed loop, 0 selects the manual offset |
| hold | input | 1 | Freezes the loop offset |
| manual_offset | input | 9 | Signed offset used in manual mode |
| cfg_wr | input | 1 | Loads all tuning fields below |
| cfg_mode | input | 2 | Update cadence code |
| cfg_shift | input | 2 | Error scaling code |
| cfg_jump | input | 1 | Large-error jump enable |
| cfg_post | input | 1 | Six-vote filter enable |
| cfg_toggle | input | 1 | Toggle filter enable |
| cfg_slew | input | 8 | Largest allowed change per update |
| offset_out | output | 9 | Signed offset to the DAC |

## Verification
The assertions assume that `clamp_done` and `vsync` are single-cycle strobes and that `sample_code` is valid in the `clamp_done` cycle. They also assume that tuning writes arrive only between update events, so the slew and vote properties refer to a single configuration. The bench drives every input at the falling edge. It spaces each strobe by at least one idle cycle and writes tuning fields only while no update is in flight. It keeps `target_code` steady across each update window.

// File: rtl/aol_pkg.sv
package aol_pkg;

   localparam int SLEW_W = 8;

   typedef enum logic [1:0] {
      DIR_NONE = 2'd0,
      DIR_UP   = 2'd1,
      DIR_DN   = 2'd2
   } dir_t;

   typedef enum logic [1:0] {
      CAD_EACH  = 2'd0,
      CAD_SHORT = 2'd1,
      CAD_LONG  = 2'd2,
      CAD_FRAME = 2'd3
   } cadence_t;

   typedef struct packed {
      cadence_t            mode;
      logic [1:0]          shift;
      logic                jump;
      logic                post;
      logic                toggle;
      logic [SLEW_W-1:0]   slew;
   } tune_t;

   localparam tune_t TUNE_RESET = '{
      mode:   CAD_LONG,
      shift:  2'd1,
      jump:   1'b1,
      post:   1'b1,
      toggle: 1'b0,
      slew:   SLEW_W'(8)
   };

endpackage

// File: rtl/aol_cadence.sv
module aol_cadence
   import aol_pkg::*;
#(
   parameter int SHORT_N = 16,
   parameter int LONG_N  = 64
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     clamp_done,
   input  logic     vsync,
   input  logic     restart,
   input  cadence_t mode,
   output logic     tick
);

   localparam int CNT_W = $clog2(LONG_N);
   localparam logic [CNT_W-1:0] SHORT_LIM = CNT_W'(SHORT_N - 1);
   localparam logic [CNT_W-1:0] LONG_LIM  = CNT_W'(LONG_N - 1);

   generate
      if (SHORT_N < 2 || LONG_N < SHORT_N) begin : g_bad_counts
         $error("aol_cadence: need 2 <= SHORT_N <= LONG_N");
      end
   endgenerate

   logic [CNT_W-1:0] clamp_cnt;
   logic [CNT_W-1:0] cnt_lim;
   logic             counted;

   always_comb begin
      cnt_lim = (mode == CAD_SHORT) ? SHORT_LIM : LONG_LIM;
      counted = (mode == CAD_SHORT) || (mode == CAD_LONG);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         clamp_cnt <= '0;
         tick      <= 1'b0;
      end else begin
         tick <= 1'b0;
         if (restart) begin
            clamp_cnt <= '0;
         end else begin
            if (clamp_done && counted) begin
               if (clamp_cnt >= cnt_lim) begin
                  clamp_cnt <= '0;
                  tick      <= 1'b1;
               end else begin
                  clamp_cnt <= clamp_cnt + 1'b1;
               end
            end
            if (clamp_done && mode == CAD_EACH) tick <= 1'b1;
            if (vsync && mode == CAD_FRAME)     tick <= 1'b1;
         end
      end
   end

   assert_tick_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> $past(clamp_done || vsync));

   assert_each_clamp_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (clamp_done && !restart && mode == CAD_EACH) |=> tick);

endmodule

// File: rtl/aol_step.sv
module aol_step
   import aol_pkg::*;
#(
   parameter int CODE_W   = 8,
   parameter int OFS_W    = 9,
   parameter int JUMP_THR = 15
) (
   input  logic [CODE_W-1:0]       code,
   input  logic [CODE_W-1:0]       target,
   input  logic [1:0]              shift,
   input  logic                    jump,
   input  logic [SLEW_W-1:0]       slew,
   input  logic signed [OFS_W-1:0] ofs_cur,
   output dir_t                    dir,
   output logic signed [OFS_W-1:0] ofs_next
);

   localparam int E_W = CODE_W + 1;
   localparam int M_W = (E_W > SLEW_W) ? E_W : SLEW_W;
   localparam int S_W = ((OFS_W > M_W) ? OFS_W : M_W) + 2;
   localparam logic signed [S_W-1:0] MAX_S = S_W'((2 ** (OFS_W - 1)) - 1);
   localparam logic signed [S_W-1:0] MIN_S = -MAX_S - S_W'(1);

   generate
      if (JUMP_THR < 1 || JUMP_THR >= 2 ** CODE_W) begin : g_bad_thr
         $error("aol_step: JUMP_THR out of code range");
      end
      if (OFS_W <= CODE_W) begin : g_bad_ofs
         $error("aol_step: offset must be wider than the code");
      end
   endgenerate

   logic signed [E_W-1:0]   err;
   logic                    err_neg;
   logic [E_W-1:0]          mag;
   logic [M_W-1:0]          step_raw;
   logic [M_W-1:0]          step_lim;
   logic signed [S_W-1:0]   cur_x;
   logic signed [S_W-1:0]   delta_x;
   logic signed [S_W-1:0]   sum_x;

   always_comb begin
      err      = $signed({1'b0, target}) - $signed({1'b0, code});
      err_neg  = err[E_W-1];
      mag      = err_neg ? E_W'(-err) : E_W'(err);
      if (jump && (mag > E_W'(JUMP_THR)))
         step_raw = M_W'(mag);
      else
         step_raw = M_W'(mag >> shift);
      step_lim = (step_raw > M_W'(slew)) ? M_W'(slew) : step_raw;

      cur_x   = {{(S_W - OFS_W){ofs_cur[OFS_W-1]}}, ofs_cur};
      delta_x = $signed({{(S_W - M_W){1'b0}}, step_lim});
      sum_x   = err_neg ? (cur_x - delta_x) : (cur_x + delta_x);

      if (sum_x > MAX_S)      ofs_next = MAX_S[OFS_W-1:0];
      else if (sum_x < MIN_S) ofs_next = MIN_S[OFS_W-1:0];
      else                    ofs_next = sum_x[OFS_W-1:0];

      if (step_lim == '0) dir = DIR_NONE;
      else if (err_neg)   dir = DIR_DN;
      else                dir = DIR_UP;
   end

endmodule

// File: rtl/aol_vote.sv
module aol_vote
   import aol_pkg::*;
#(
   parameter int VOTES = 6,
   parameter int OFS_W = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    tick,
   input  logic                    active,
   input  logic                    clear,
   input  logic                    post_en,
   input  logic                    toggle_en,
   input  dir_t                    dir,
   input  logic signed [OFS_W-1:0] ofs_cur,
   input  logic signed [OFS_W-1:0] ofs_next,
   output logic                    apply,
   output logic                    held
);

   generate
      if (VOTES < 1) begin : g_bad_votes
         $error("aol_vote: VOTES must be at least 1");
      end
   endgenerate

   logic eval;
   logic post_ok;

   assign eval = tick && active && !held;

   generate
      if (VOTES > 1) begin : g_post
         localparam int CW = $clog2(VOTES);
         logic [CW-1:0] vote_cnt;
         dir_t          last_vdir;
         logic          full;

         assign full    = (dir != DIR_NONE) && (dir == last_vdir) &&
                          (vote_cnt == CW'(VOTES - 1));
         assign post_ok = full;

         always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
               vote_cnt  <= '0;
               last_vdir <= DIR_NONE;
            end else if (eval) begin
               last_vdir <= dir;
               if (dir == DIR_NONE || full)  vote_cnt <= '0;
               else if (dir == last_vdir)    vote_cnt <= vote_cnt + 1'b1;
               else                          vote_cnt <= CW'(1);
            end
         end

         assert_six_votes_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (post_en && apply) |-> (vote_cnt == CW'(VOTES - 1)));
      end else begin : g_no_post
         assign post_ok = (dir != DIR_NONE);
      end
   endgenerate

   assign apply = eval && (post_en ? post_ok : (dir != DIR_NONE));

   logic signed [OFS_W-1:0] prev_ofs;
   dir_t                    last_adir;
   dir_t                    last_edir;
   logic                    flips;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_ofs  <= '0;
         last_adir <= DIR_NONE;
         last_edir <= DIR_NONE;
         flips     <= 1'b0;
         held      <= 1'b0;
      end else if (clear || !toggle_en) begin
         last_adir <= DIR_NONE;
         last_edir <= DIR_NONE;
         flips     <= 1'b0;
         held      <= 1'b0;
      end else begin
         if (tick && active && dir != DIR_NONE) begin
            last_edir <= dir;
            if (held && last_edir != DIR_NONE && dir != last_edir) begin
               if (flips) begin
                  held      <= 1'b0;
                  flips     <= 1'b0;
                  last_adir <= DIR_NONE;
               end else begin
                  flips <= 1'b1;
               end
            end
         end
         if (apply) begin
            prev_ofs  <= ofs_cur;
            last_adir <= dir;
            if (last_adir != DIR_NONE && dir != last_adir && ofs_next == prev_ofs) begin
               held  <= 1'b1;
               flips <= 1'b0;
            end
         end
      end
   end

endmodule

// File: rtl/auto_offset_loop.sv
module auto_offset_loop
   import aol_pkg::*;
#(
   parameter int CODE_W   = 8,
   parameter int OFS_W    = 9,
   parameter int SHORT_N  = 16,
   parameter int LONG_N   = 64,
   parameter int VOTES    = 6,
   parameter int JUMP_THR = 15
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clamp_done,
   input  logic                    vsync,
   input  logic [CODE_W-1:0]       sample_code,
   input  logic [CODE_W-1:0]       target_code,
   input  logic                    auto_en,
   input  logic                    hold,
   input  logic signed [OFS_W-1:0] manual_offset,
   input  logic                    cfg_wr,
   input  logic [1:0]              cfg_mode,
   input  logic [1:0]              cfg_shift,
   input  logic                    cfg_jump,
   input  logic                    cfg_post,
   input  logic                    cfg_toggle,
   input  logic [SLEW_W-1:0]       cfg_slew,
   output logic signed [OFS_W-1:0] offset_out
);

   tune_t                   tune_q;
   logic [CODE_W-1:0]       code_q;
   logic signed [OFS_W-1:0] loop_q;
   logic                    upd_tick;
   logic                    active;
   logic                    clear;
   dir_t                    step_dir;
   logic signed [OFS_W-1:0] step_next;
   logic                    do_apply;
   logic                    tog_held;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tune_q <= TUNE_RESET;
      end else if (cfg_wr) begin
         tune_q <= '{mode: cadence_t'(cfg_mode), shift: cfg_shift, jump: cfg_jump,
                     post: cfg_post, toggle: cfg_toggle, slew: cfg_slew};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          code_q <= '0;
      else if (clamp_done) code_q <= sample_code;
   end

   aol_cadence #(.SHORT_N(SHORT_N), .LONG_N(LONG_N)) i_cadence (
      .clk        (clk),
      .rst_n      (rst_n),
      .clamp_done (clamp_done),
      .vsync      (vsync),
      .restart    (cfg_wr),
      .mode       (tune_q.mode),
      .tick       (upd_tick)
   );

   aol_step #(.CODE_W(CODE_W), .OFS_W(OFS_W), .JUMP_THR(JUMP_THR)) i_step (
      .code     (code_q),
      .target   (target_code),
      .shift    (tune_q.shift),
      .jump     (tune_q.jump),
      .slew     (tune_q.slew),
      .ofs_cur  (loop_q),
      .dir      (step_dir),
      .ofs_next (step_next)
   );

   assign active = auto_en && !hold;
   assign clear  = cfg_wr || !auto_en;

   aol_vote #(.VOTES(VOTES), .OFS_W(OFS_W)) i_vote (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (upd_tick),
      .active    (active),
      .clear     (clear),
      .post_en   (tune_q.post),
      .toggle_en (tune_q.toggle),
      .dir       (step_dir),
      .ofs_cur   (loop_q),
      .ofs_next  (step_next),
      .apply     (do_apply),
      .held      (tog_held)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)        loop_q <= '0;
      else if (!auto_en) loop_q <= manual_offset;
      else if (do_apply) loop_q <= step_next;
   end

   assign offset_out = auto_en ? loop_q : manual_offset;

   logic signed [OFS_W-1:0] chk_prev;
   logic signed [OFS_W:0]   chk_step;
   logic [OFS_W:0]          chk_abs;

   always_ff @(posedge clk) begin
      if (!rst_n) chk_prev <= '0;
      else        chk_prev <= loop_q;
   end

   always_comb begin
      chk_step = {loop_q[OFS_W-1], loop_q} - {chk_prev[OFS_W-1], chk_prev};
      chk_abs  = chk_step[OFS_W] ? (OFS_W + 1)'(-chk_step) : (OFS_W + 1)'(chk_step);
   end

   assert_slew_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(auto_en) && auto_en) |-> (chk_abs <= (OFS_W + 1)'($past(tune_q.slew))));

   assert_hold_freeze_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(auto_en) && $past(hold) && auto_en) |-> $stable(offset_out));

   assert_toggle_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(auto_en) && $past(tog_held) && auto_en) |-> $stable(offset_out));

endmodule

// File: tb/test_auto_offset_loop.sv
module test_auto_offset_loop;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             clamp_done = 1'b0;
   logic             vsync = 1'b0;
   logic [7:0]       sample_code = 8'd0;
   logic [7:0]       target_code = 8'd0;
   logic             auto_en = 1'b0;
   logic             hold = 1'b0;
   logic signed [8:0] manual_offset = '0;
   logic             cfg_wr = 1'b0;
   logic [1:0]       cfg_mode = 2'd0;
   logic [1:0]       cfg_shift = 2'd0;
   logic             cfg_jump = 1'b0;
   logic             cfg_post = 1'b0;
   logic             cfg_toggle = 1'b0;
   logic [7:0]       cfg_slew = 8'd0;
   logic signed [8:0] offset_out;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   auto_offset_loop i_auto_offset_loop (
      .clk           (clk),
      .rst_n         (rst_n),
      .clamp_done    (clamp_done),
      .vsync         (vsync),
      .sample_code   (sample_code),
      .target_code   (target_code),
      .auto_en       (auto_en),
      .hold          (hold),
      .manual_offset (manual_offset),
      .cfg_wr        (cfg_wr),
      .cfg_mode      (cfg_mode),
      .cfg_shift     (cfg_shift),
      .cfg_jump      (cfg_jump),
      .cfg_post      (cfg_post),
      .cfg_toggle    (cfg_toggle),
      .cfg_slew      (cfg_slew),
      .offset_out    (offset_out)
   );

   // columns: start offset, code, target, shift, jump, slew, expected
   localparam int NV = 13;
   localparam int VEC [NV][7] = '{
      '{   0, 100, 104, 0, 1,   8,    4},  // R4 full error
      '{   0, 110, 100, 1, 1,   8,   -5},  // R4 half, negative
      '{  10, 100, 107, 2, 1,   8,   11},  // R4 quarter truncates
      '{  20, 100,  93, 3, 1,   8,   20},  // R4 eighth rounds to zero
      '{  20, 100,  90, 3, 1,   8,   19},  // R4 toward zero, not floor
      '{   0,  50, 100, 0, 1, 255,   50},  // R5 jump full error
      '{   0,  50, 100, 1, 0, 255,   25},  // R5 jump off: shifted
      '{   0,  50, 100, 1, 1,   8,    8},  // R8 jump limited by slew
      '{   0, 200, 100, 0, 1,  20,  -20},  // R8 negative slew limit
      '{   0, 100, 115, 2, 1, 255,    3},  // R5 error 15 not a jump
      '{   0, 100, 116, 2, 1, 255,   16},  // R5 error 16 jumps
      '{ 250, 100, 150, 0, 1, 255,  255},  // R9 upper saturation
      '{-250, 200, 100, 0, 1, 255, -256}   // R9 lower saturation
   };

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic write_cfg(input int mode, input int sh, input bit jmp,
                            input bit post, input bit tog, input int slew);
      cfg_mode   = 2'(mode);
      cfg_shift  = 2'(sh);
      cfg_jump   = jmp;
      cfg_post   = post;
      cfg_toggle = tog;
      cfg_slew   = 8'(slew);
      cfg_wr     = 1'b1;
      @(negedge clk);
      cfg_wr     = 1'b0;
   endtask

   task automatic clamp(input int code);
      sample_code = 8'(code);
      clamp_done  = 1'b1;
      @(negedge clk);
      clamp_done  = 1'b0;
      @(negedge clk);
   endtask

   task automatic start_from(input int m);
      auto_en       = 1'b0;
      manual_offset = 9'(m);
      @(negedge clk);
   endtask

   initial begin
      #(8 * 200000);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      manual_offset = 9'sd37;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset manual passthrough", int'(offset_out), 37);

      // reset tuning: every 64th clamp, six votes, jump, slew 8
      manual_offset = '0;
      @(negedge clk);
      auto_en     = 1'b1;
      target_code = 8'd140;
      for (int i = 0; i < 383; i++) clamp(100);
      check("R3 R6 defaults before sixth update", int'(offset_out), 0);
      clamp(100);
      check("R3 R6 R8 defaults sixth update", int'(offset_out), 8);

      // vector table, one update per row
      for (int v = 0; v < NV; v++) begin
         start_from(VEC[v][0]);
         write_cfg(0, VEC[v][3], VEC[v][4] != 0, 1'b0, 1'b0, VEC[v][5]);
         auto_en     = 1'b1;
         target_code = 8'(VEC[v][2]);
         clamp(VEC[v][1]);
         check($sformatf("R4/R5/R8/R9 vector %0d", v), int'(offset_out), VEC[v][6]);
      end

      // R1: manual mode ignores updates
      start_from(-17);
      write_cfg(0, 0, 1'b0, 1'b0, 1'b0, 8);
      target_code = 8'd120;
      clamp(100);
      check("R1 manual ignores clamp", int'(offset_out), -17);

      // R2: hold
      start_from(0);
      write_cfg(0, 0, 1'b0, 1'b0, 1'b0, 8);
      auto_en     = 1'b1;
      hold        = 1'b1;
      target_code = 8'd104;
      clamp(100);
      check("R2 hold freezes", int'(offset_out), 0);
      hold = 1'b0;
      clamp(100);
      check("R2 release hold", int'(offset_out), 4);

      // R3: cadence every 16th clamp
      start_from(0);
      write_cfg(1, 0, 1'b0, 1'b0, 1'b0, 8);
      auto_en     = 1'b1;
      target_code = 8'd101;
      for (int i = 0; i < 15; i++) clamp(100);
      check("R3 mode1 after 15 clamps", int'(offset_out), 0);
      clamp(100);
      check("R3 mode1 after 16 clamps", int'(offset_out), 1);

      // R3: every 64th clamp
      start_from(0);
      write_cfg(2, 0, 1'b0, 1'b0, 1'b0, 8);
      auto_en = 1'b1;
      for (int i = 0; i < 63; i++) clamp(100);
      check("R3 mode2 after 63 clamps", int'(offset_out), 0);
      clamp(100);
      check("R3 mode2 after 64 clamps", int'(offset_out), 1);

      // R3: vsync cadence
      start_from(0);
      write_cfg(3, 0, 1'b0, 1'b0, 1'b0, 8);
      auto_en = 1'b1;
      for (int i = 0; i < 5; i++) clamp(100);
      check("R3 mode3 clamps alone", int'(offset_out), 0);
      vsync = 1'b1;
      @(negedge clk);
      vsync = 1'b0;
      @(negedge clk);
      check("R3 mode3 vsync update", int'(offset_out), 1);

      // R6: six votes, restart on zero vote and on reversal
      start_from(0);
      write_cfg(0, 0, 1'b0, 1'b1, 1'b0, 8);
      auto_en     = 1'b1;
      target_code = 8'd104;
      for (int i = 0; i < 5; i++) clamp(100);
      check("R6 five votes", int'(offset_out), 0);
      clamp(100);
      check("R6 six votes", int'(offset_out), 4);
      for (int i = 0; i < 3; i++) clamp(108);
      clamp(104);
      for (int i = 0; i < 5; i++) clamp(108);
      check("R6 zero vote restarts count", int'(offset_out), 4);
      clamp(108);
      check("R6 six after restart", int'(offset_out), 0);
      for (int i = 0; i < 4; i++) clamp(100);
      for (int i = 0; i < 5; i++) clamp(108);
      check("R6 reversal restarts count", int'(offset_out), 0);

      // R7: toggle filter
      start_from(0);
      write_cfg(0, 0, 1'b0, 1'b0, 1'b1, 8);
      auto_en     = 1'b1;
      target_code = 8'd103;
      clamp(100);
      check("R7 first step", int'(offset_out), 3);
      clamp(106);
      check("R7 return step", int'(offset_out), 0);
      clamp(100);
      check("R7 locked after toggle", int'(offset_out), 0);
      clamp(106);
      check("R7 still locked", int'(offset_out), 0);
      clamp(100);
      check("R7 released after two flips", int'(offset_out), 3);

      start_from(0);
      write_cfg(0, 0, 1'b0, 1'b0, 1'b0, 8);
      auto_en = 1'b1;
      clamp(100);
      clamp(106);
      clamp(100);
      check("R7 filter off keeps toggling", int'(offset_out), 3);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule